// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block models a single-port synchronous static memory organised as 32-bit words in four 8-bit lanes. An access begins when one of two address strobes loads an external address while the chip is selected. The selection comes from three chip-select inputs, and those inputs are looked at only on the edge where an address is loaded. After the load, a 2-bit burst counter walks through the other words of the aligned 4-word block on each edge where the burst-advance input is low. A processor-side strobe is gated by the first chip select and always starts a read. A controller-side strobe is not gated and honours the write inputs on the same edge.

Writes either cover the whole word through a global write input, or cover the lanes picked by per-lane selects when the byte-write enable is low. Reads pass through a one-stage output register. The data bus is split into an input port and an output port, with a drive flag in place of tri-state pads. The drive flag follows the active-low output enable without waiting for a clock edge. It is held off on the first read after a deselected period. The word count is a parameter, and the default is kept small enough for a fast model.

Top module: `burst_sram`

## Requirements
- R1: When a strobe loads an address with sel_a_n=0, sel_b=1 and sel_c_n=0, and no write is requested, the word at that address appears on dout after that edge, and dq_drive=1 if out_en_n=0 and the chip was already selected before the edge.
- R2: cpu_strobe_n=0 has no effect while sel_a_n=1. ctl_strobe_n=0 loads an address even with sel_a_n=1, and in that case it deselects the chip.
- R3: The chip-select inputs are sampled only on an edge that loads an address. Between loads, the selected or deselected state is held.
- R4: A load seeds the burst counter from addr[1:0]. Each following edge with burst_next_n=0 accesses the next word in the order 0,1,2,3,0 within the 4-word block, and the upper address bits stay unchanged. A load on the same edge takes precedence over the advance. An edge with neither a load nor an advance accesses the same word again.
- R5: With wr_all_n=0 on a write edge, all 32 bits are written, whatever the values of wr_bytes_n and lane_sel_n.
- R6: With wr_all_n=1 and wr_bytes_n=0, lane i (din[8i+7:8i]) is written only when lane_sel_n[i]=0, and the other lanes keep their contents. With both wr_all_n=1 and wr_bytes_n=1, the edge is a read.
- R7: A load by cpu_strobe_n is always a read, and the write inputs are ignored on that edge. When both strobes are low and sel_a_n=0, cpu_strobe_n takes priority. A load by ctl_strobe_n alone honours the write inputs on that same edge.
- R8: dq_drive is 0 whenever out_en_n=1, and it follows out_en_n without waiting for a clock edge.
- R9: On the first read edge after a deselected state, which includes the state after reset, dq_drive stays 0 for that cycle even with out_en_n=0. The next read drives normally.
- R10: After a write edge, or an edge taken while deselected, dq_drive is 0.
- R11: While rst_n is low, dout is 0, dq_drive is 0, and the chip is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, low 2 bits seed the burst |
| cpu_strobe_n | input | 1 | Processor-side address strobe, gated by sel_a_n |
| ctl_strobe_n | input | 1 | Controller-side address strobe |
| burst_next_n | input | 1 | Advance the burst counter, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_bytes_n | input | 1 | Byte-lane write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, acts without a clock |
| din | input | 32 | Write data |
| dout | output | 32 | Registered read data |
| dq_drive | output | 1 | Output bus is driven |

## Verification
A wrong stored address, or a wrong counter, shows at the port as the wrong word on dout one edge after the faulty access. So a burst error is seen on the very cycle the counter steps wrong or fails to wrap. A stale selection shows at once as dq_drive rising or staying low on the next read. A lane-decode error stays hidden until that word is read again, so each write in the tests is followed by a read that exposes every lane. A missing first-read mask is visible only on the first cycle after a reselect.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int unsigned LANE_W    = 8;
    localparam int unsigned NUM_LANES = 4;
    localparam int unsigned DATA_W    = LANE_W * NUM_LANES;
    localparam int unsigned BURST_W   = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/bsr_addr_ctrl.sv
module bsr_addr_ctrl
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              burst_next_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_sel,
    output logic              prev_sel,
    output logic              cpu_load
);

    localparam int unsigned BASE_W = ADDR_W - BURST_W;

    typedef struct packed {
        logic              sel;
        logic [BASE_W-1:0] base;
        logic [BURST_W-1:0] cnt;
    } ctl_t;

    ctl_t st_d, st_q;
    logic load;

    always_comb begin
        cpu_load = !cpu_strobe_n && !sel_a_n;
        load     = cpu_load || !ctl_strobe_n;
        st_d     = st_q;
        if (load) begin
            st_d.sel  = !sel_a_n && sel_b && !sel_c_n;
            st_d.base = addr[ADDR_W-1:BURST_W];
            st_d.cnt  = addr[BURST_W-1:0];
        end else if (!burst_next_n) begin
            st_d.cnt = st_q.cnt + BURST_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_addr = {st_d.base, st_d.cnt};
    assign acc_sel  = st_d.sel;
    assign prev_sel = st_q.sel;

    // R1: a selected load captures the address
    p_load_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !sel_a_n && sel_b && !sel_c_n) |=>
            (st_q.sel && st_q.base == $past(addr[ADDR_W-1:BURST_W])
                      && st_q.cnt == $past(addr[BURST_W-1:0])));

    // R2: gated strobe alone changes nothing
    p_cpu_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && sel_a_n && ctl_strobe_n && burst_next_n) |=>
            $stable(st_q));

    // R3: selection is held between loads
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.sel));

    // R4: advance steps within the block
    p_burst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !burst_next_n) |=>
            (st_q.cnt == $past(st_q.cnt) + BURST_W'(1) && $stable(st_q.base)));

endmodule

// File: rtl/bsr_lane_decode.sv
module bsr_lane_decode
    import burst_sram_pkg::*;
(
    input  logic                 wr_all_n,
    input  logic                 wr_bytes_n,
    input  logic [NUM_LANES-1:0] lane_sel_n,
    input  logic                 acc_sel,
    input  logic                 cpu_load,
    output logic [NUM_LANES-1:0] lane_we,
    output acc_kind_e            acc_kind
);

    logic [NUM_LANES-1:0] lanes_req;
    logic                 wr_req;

    always_comb begin
        wr_req = !wr_all_n || !wr_bytes_n;
        if (!wr_all_n)        lanes_req = '1;
        else if (!wr_bytes_n) lanes_req = ~lane_sel_n;
        else                  lanes_req = '0;

        if (!acc_sel) begin
            acc_kind = ACC_IDLE;
            lane_we  = '0;
        end else if (cpu_load || !wr_req) begin
            acc_kind = ACC_READ;
            lane_we  = '0;
        end else begin
            acc_kind = ACC_WRITE;
            lane_we  = lanes_req;
        end
    end

endmodule

// File: rtl/bsr_array.sv
module bsr_array
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 clk,
    input  logic [NUM_LANES-1:0] lane_we,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) cells[acc_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[acc_addr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 cpu_strobe_n,
    input  logic                 ctl_strobe_n,
    input  logic                 burst_next_n,
    input  logic                 sel_a_n,
    input  logic                 sel_b,
    input  logic                 sel_c_n,
    input  logic                 wr_all_n,
    input  logic                 wr_bytes_n,
    input  logic [NUM_LANES-1:0] lane_sel_n,
    input  logic                 out_en_n,
    input  logic [DATA_W-1:0]    din,
    output logic [DATA_W-1:0]    dout,
    output logic                 dq_drive
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              vld;
        logic              mask;
    } out_t;

    logic [ADDR_W-1:0]    acc_addr;
    logic                 acc_sel;
    logic                 prev_sel;
    logic                 cpu_load;
    logic [NUM_LANES-1:0] lane_we;
    acc_kind_e            acc_kind;
    logic [DATA_W-1:0]    arr_rdata;
    out_t                 out_d, out_q;

    bsr_addr_ctrl #(.ADDR_W(ADDR_W)) i_addr_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .burst_next_n (burst_next_n),
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .acc_addr     (acc_addr),
        .acc_sel      (acc_sel),
        .prev_sel     (prev_sel),
        .cpu_load     (cpu_load)
    );

    bsr_lane_decode i_lane_decode (
        .wr_all_n   (wr_all_n),
        .wr_bytes_n (wr_bytes_n),
        .lane_sel_n (lane_sel_n),
        .acc_sel    (acc_sel),
        .cpu_load   (cpu_load),
        .lane_we    (lane_we),
        .acc_kind   (acc_kind)
    );

    bsr_array #(.ADDR_W(ADDR_W)) i_array (
        .clk      (clk),
        .lane_we  (lane_we),
        .acc_addr (acc_addr),
        .wdata    (din),
        .rdata    (arr_rdata)
    );

    always_comb begin
        out_d       = out_q;
        out_d.vld   = (acc_kind == ACC_READ);
        out_d.mask  = (acc_kind == ACC_READ) && !prev_sel;
        if (acc_kind == ACC_READ) out_d.rdata = arr_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dout     = out_q.rdata;
    assign dq_drive = !out_en_n && out_q.vld && !out_q.mask;

    // R5: global write covers every lane
    p_gw_all_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_all_n && acc_kind == ACC_WRITE) |-> (lane_we == '1));

    // R7: a gated-strobe load never writes
    p_cpu_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_load |-> (lane_we == '0));

    // R8: output enable high keeps the bus off
    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !dq_drive);

    // R9: first read after a deselect is masked
    p_first_read_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_READ && !prev_sel) |=> !dq_drive);

    // R10: no drive after a write or a deselected edge
    p_wr_no_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind != ACC_READ) |=> !dq_drive);

endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;

    localparam int unsigned AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic        cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, burst_next_n = 1'b1;
    logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic        wr_all_n = 1'b1, wr_bytes_n = 1'b1;
    logic [3:0]  lane_sel_n = 4'hF;
    logic        out_en_n = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] dout;
    logic        dq_drive;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) i_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .burst_next_n(burst_next_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n),
        .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .din(din),
        .dout(dout), .dq_drive(dq_drive)
    );

    // control bits: cpu_strobe_n, ctl_strobe_n, burst_next_n, sel_a_n, sel_b, sel_c_n, wr_all_n, wr_bytes_n
    localparam logic [7:0] C_IDLE      = 8'b11101011;
    localparam logic [7:0] C_CTL_GW    = 8'b10101001;
    localparam logic [7:0] C_ADV_GW    = 8'b11001001;
    localparam logic [7:0] C_CPU_GW    = 8'b01101001;
    localparam logic [7:0] C_ADV       = 8'b11001011;
    localparam logic [7:0] C_CTL_BW    = 8'b10101010;
    localparam logic [7:0] C_CTL_DESEL = 8'b10100011;
    localparam logic [7:0] C_CPU_SAHI  = 8'b01111011;
    localparam logic [7:0] C_CPU_RD    = 8'b01101011;
    localparam logic [7:0] C_CTL_SAHI  = 8'b10111011;
    localparam logic [7:0] C_BOTH_GW   = 8'b00101001;
    localparam logic [7:0] C_CTL_ADV   = 8'b10001011;

    typedef struct packed {
        logic [7:0]  ctl;
        logic [3:0]  bw;
        logic        oe;
        logic [7:0]  a;
        logic [31:0] d;
        logic        chk_d;
        logic        exp_en;
        logic [31:0] exp_d;
        logic [3:0]  req;
    } vec_t;

    localparam int N_VEC = 24;
    localparam vec_t TBL [N_VEC] = '{
        '{C_CTL_GW,    4'hF, 1'b0, 8'h10, 32'hA0A1A2A3, 1'b0, 1'b0, 32'h0,        4'd5},  // R5 write 0x10
        '{C_ADV_GW,    4'hF, 1'b0, 8'h00, 32'hB0B1B2B3, 1'b0, 1'b0, 32'h0,        4'd4},  // R4 burst write 0x11
        '{C_ADV_GW,    4'hF, 1'b0, 8'h00, 32'hC0C1C2C3, 1'b0, 1'b0, 32'h0,        4'd4},
        '{C_ADV_GW,    4'hF, 1'b0, 8'h00, 32'hD0D1D2D3, 1'b0, 1'b0, 32'h0,        4'd10}, // R10
        '{C_CPU_GW,    4'hF, 1'b0, 8'h12, 32'hEEEEEEEE, 1'b1, 1'b1, 32'hC0C1C2C3, 4'd7},  // R7 no write
        '{C_ADV,       4'hF, 1'b0, 8'h00, 32'h0,        1'b1, 1'b1, 32'hD0D1D2D3, 4'd4},
        '{C_ADV,       4'hF, 1'b0, 8'h00, 32'h0,        1'b1, 1'b1, 32'hA0A1A2A3, 4'd4},  // R4 wrap
        '{C_ADV,       4'hF, 1'b0, 8'h00, 32'h0,        1'b1, 1'b1, 32'hB0B1B2B3, 4'd4},
        '{C_CTL_BW,    4'hA, 1'b0, 8'h11, 32'h11223344, 1'b0, 1'b0, 32'h0,        4'd6},  // R6 lanes 0,2
        '{C_IDLE,      4'hF, 1'b0, 8'h00, 32'h0,        1'b1, 1'b1, 32'hB022B244, 4'd6},
        '{C_CTL_GW,    4'hF, 1'b0, 8'h11, 32'h55667788, 1'b0, 1'b0, 32'h0,        4'd5},  // R5 overrides
        '{C_IDLE,      4'hF, 1'b0, 8'h00, 32'h0,        1'b1, 1'b1, 32'h55667788, 4'd5},
        '{C_CTL_DESEL, 4'hF, 1'b0, 8'h20, 32'h0,        1'b0, 1'b0, 32'h0,        4'd10},
        '{C_IDLE,      4'hF, 1'b0, 8'h00, 32'h0,        1'b0, 1'b0, 32'h0,        4'd3},  // R3 hold
        '{C_CPU_SAHI,  4'hF, 1'b0, 8'h10, 32'h0,        1'b0, 1'b0, 32'h0,        4'd2},  // R2 ignored
        '{C_CPU_RD,    4'hF, 1'b0, 8'h10, 32'h0,        1'b0, 1'b0, 32'h0,        4'd9},  // R9 masked
        '{C_IDLE,      4'hF, 1'b0, 8'h00, 32'h0,        1'b1, 1'b1, 32'hA0A1A2A3, 4'd9},
        '{C_IDLE,      4'hF, 1'b1, 8'h00, 32'h0,        1'b0, 1'b0, 32'h0,        4'd8},  // R8
        '{C_CTL_SAHI,  4'hF, 1'b0, 8'h12, 32'h0,        1'b0, 1'b0, 32'h0,        4'd2},  // R2 deselect
        '{C_BOTH_GW,   4'hF, 1'b0, 8'h13, 32'hFFFF0000, 1'b0, 1'b0, 32'h0,        4'd7},  // R7 priority
        '{C_IDLE,      4'hF, 1'b0, 8'h00, 32'h0,        1'b1, 1'b1, 32'hD0D1D2D3, 4'd7},
        '{C_CTL_GW,    4'hF, 1'b0, 8'h13, 32'h13579BDF, 1'b0, 1'b0, 32'h0,        4'd7},
        '{C_IDLE,      4'hF, 1'b0, 8'h00, 32'h0,        1'b1, 1'b1, 32'h13579BDF, 4'd1},  // R1
        '{C_CTL_ADV,   4'hF, 1'b0, 8'h12, 32'h0,        1'b1, 1'b1, 32'hC0C1C2C3, 4'd4}   // R4 load wins
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] c, input logic [3:0] bw, input logic oe,
                         input logic [7:0] a, input logic [31:0] d);
        {cpu_strobe_n, ctl_strobe_n, burst_next_n, sel_a_n, sel_b, sel_c_n,
         wr_all_n, wr_bytes_n} = c;
        lane_sel_n = bw;
        out_en_n   = oe;
        addr       = a;
        din        = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ref_word;
        repeat (3) @(negedge clk);
        check("R11 dout in reset", dout, 32'h0);
        check("R11 drive in reset", {31'h0, dq_drive}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < N_VEC; i++) begin
            string rq;
            drive(TBL[i].ctl, TBL[i].bw, TBL[i].oe, TBL[i].a, TBL[i].d);
            rq = $sformatf("R%0d vec %0d", TBL[i].req, i);
            check(rq, {31'h0, dq_drive}, {31'h0, TBL[i].exp_en});
            if (TBL[i].chk_d) check(rq, dout, TBL[i].exp_d);
        end

        // R8: enable acts without a clock edge
        #3 out_en_n = 1'b1;
        #2 check("R8 async off", {31'h0, dq_drive}, 32'h0);
        out_en_n = 1'b0;
        #2 check("R8 async on", {31'h0, dq_drive}, 32'h1);
        @(negedge clk);

        // R6: one lane at a time, every other lane must survive
        drive(C_CTL_GW, 4'hF, 1'b0, 8'h30, 32'h00000000);
        ref_word = 32'h0;
        for (int ln = 0; ln < 4; ln++) begin
            logic [3:0] sel;
            logic [31:0] pat;
            sel = ~(4'b0001 << ln);
            pat = 32'h5A5A5A5A ^ (32'h01010101 * (ln + 1));
            drive(C_CTL_BW, sel, 1'b0, 8'h30, pat);
            ref_word[ln*8 +: 8] = pat[ln*8 +: 8];
            drive(C_IDLE, 4'hF, 1'b0, 8'h00, 32'h0);
            check($sformatf("R6 lane %0d", ln), dout, ref_word);
        end

        // R11: reset mid-run, then R9 first read after reset is masked
        #3 rst_n = 1'b0;
        #2 check("R11 dout after reset", dout, 32'h0);
        check("R11 drive after reset", {31'h0, dq_drive}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive(C_CPU_RD, 4'hF, 1'b0, 8'h10, 32'h0);
        check("R9 mask after reset", {31'h0, dq_drive}, 32'h0);
        drive(C_IDLE, 4'hF, 1'b0, 8'h00, 32'h0);
        check("R9 second read drives", {31'h0, dq_drive}, 32'h1);
        check("R1 data kept", dout, 32'hA0A1A2A3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule